// File: doc/BRIEF.md
# Priority Maskable Interrupt Arbiter

This block sits between a bank of maskable interrupt request lines and a CPU core. A one-cycle high on any request line sets a pending flag for that source. Each source has a mask bit and a 3-bit priority level, where level 0 is the most urgent. Every cycle, the block selects one winner among the pending, unmasked sources. It picks the smallest level value first and breaks a tie by taking the lowest source index. It then offers that winner to the core as an acknowledge request.

The offer is gated by three things: the core's interrupt-disable flag (`core_id`), the core's non-maskable-in-progress flag (`core_np`), and a stack of the levels now in service. A new acknowledge is allowed during servicing only when its level is strictly more urgent than the top of that stack. A request at an equal or less urgent level waits.

The acknowledge leaves the block on a valid/ready channel (`ack_valid`, `ack_ready`, carrying `ack_index` and `ack_level`). The transfer happens on a clock edge where both `ack_valid` and `ack_ready` are 1. That edge clears the winner's pending flag and pushes its level onto the in-service stack. While `ack_ready` is held low, the source stays pending and remains on offer.

Unlike a data stream, this channel may withdraw its offer. `ack_valid` drops, or the offered index changes, when the core raises ID or NP, when the winner's mask is set, or when a more urgent source becomes pending. The core must therefore sample the payload only on the transfer edge. A one-cycle `svc_done` pulse ends the innermost service and pops the stack.

Top module: `irq_prio_arb`

## Requirements
- R1: A request line that is high for one clock edge sets that source's pending flag. With nothing blocking, `ack_valid` is 1 in the following cycle, `ack_index` gives the source number and `ack_level` gives its programmed level. After reset nothing is pending and `ack_valid` is 0.
- R2: A source whose mask bit is 1 is never offered. Its pending flag is kept, and the source is offered once the mask bit returns to 0.
- R3: Among offerable sources, the one with the numerically smallest level wins. Level 0 is the most urgent and level 7 the least.
- R4: Among offerable sources that share the winning level, the lowest source index wins.
- R5: While `core_id` or `core_np` is 1, `ack_valid` is 0 and every pending flag is kept. When both flags are 0 again, the pending sources are arbitrated under R3 and R4.
- R6: While the in-service stack is not empty, only a source whose level is strictly smaller than the top entry may be offered. A source at an equal or larger level stays pending.
- R7: A pending flag is cleared only on the edge where `ack_valid` and `ack_ready` are both 1, and only for the source named by `ack_index`. While `ack_ready` is 0 the offer is held.
- R8: A `svc_done` pulse removes the top entry of the in-service stack, and the entry below it then governs R6. A pulse while the stack is empty has no effect.
- R9: The in-service stack holds up to eight entries, one for each level, and never overflows. Nesting through all eight levels is possible.
- R10: If a source's request line is high on the same edge on which that source is acknowledged, the flag ends up cleared: the clear wins over the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Request lines, one per source; high sets pending |
| irq_mask | input | N_SRC | Mask bits; 1 hides the source from arbitration |
| irq_level | input | 3*N_SRC | Priority level per source, 3 bits each, source i at bits [3i+2:3i] |
| core_id | input | 1 | Core interrupt-disable flag; 1 blocks all acknowledges |
| core_np | input | 1 | Core non-maskable-in-progress flag; 1 blocks all acknowledges |
| ack_valid | output | 1 | An acknowledge is on offer |
| ack_ready | input | 1 | Core accepts the offer on this edge |
| ack_index | output | IDX_W | Source number of the offer |
| ack_level | output | 3 | Level of the offer |
| svc_done | input | 1 | End of the innermost service; pops the stack |

## Verification
The embedded assertions check, on every cycle, the properties that can be stated locally. An offer never names a masked or non-pending source, and no offer is made while ID or NP is set. A push onto a non-empty stack always carries a strictly more urgent level. The stack never grows past eight. A pending flag survives every cycle in which it is not cleared, and a clear always wins.

Which source wins among several, and the exact cycle at which a held request reappears, can only be shown by the bench's directed scenarios. These cover release after unmask, release after ID or NP fall, release after a stack pop, and eight-deep nesting. They compare the observed index and level against values worked out from the rules above.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  parameter int unsigned LVL_W   = 3;
  localparam int unsigned NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_SRC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (clr[i]) pend[i] <= 1'b0;
      else if (req[i]) pend[i] <= 1'b1;
    end

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr[i]) |=> pend[i]);                    // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !pend[i]);                                 // R10
  end
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 40,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N_SRC-1:0]       elig,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output logic                   win_v,
  output lvl_t                   win_lvl,
  output logic [IDX_W-1:0]       win_idx
);
  localparam int unsigned LEAVES = 1 << $clog2(N_SRC);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic             nd_v [NODES];
  lvl_t             nd_l [NODES];
  logic [IDX_W-1:0] nd_i [NODES];

  // leaves in index order; left subtrees always hold lower indices
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N_SRC) begin : g_real
      assign nd_v[LEAVES-1+i] = elig[i];
      assign nd_l[LEAVES-1+i] = lvl_flat[i*LVL_W +: LVL_W];
      assign nd_i[LEAVES-1+i] = IDX_W'(i);
    end else begin : g_pad
      assign nd_v[LEAVES-1+i] = 1'b0;
      assign nd_l[LEAVES-1+i] = '1;
      assign nd_i[LEAVES-1+i] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_left;
    // ties go left so the lower index survives
    assign take_left = nd_v[2*k+1] &&
                       (!nd_v[2*k+2] || (nd_l[2*k+1] <= nd_l[2*k+2]));
    assign nd_v[k] = nd_v[2*k+1] || nd_v[2*k+2];
    assign nd_l[k] = take_left ? nd_l[2*k+1] : nd_l[2*k+2];
    assign nd_i[k] = take_left ? nd_i[2*k+1] : nd_i[2*k+2];
  end

  assign win_v   = nd_v[0];
  assign win_lvl = nd_l[0];
  assign win_idx = nd_i[0];
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic busy,
  output lvl_t top_lvl
);
  localparam int unsigned DEP_W = $clog2(NUM_LVL + 1);
  localparam int unsigned PTR_W = $clog2(NUM_LVL);

  lvl_t             slot [NUM_LVL];
  logic [DEP_W-1:0] depth;
  logic [DEP_W-1:0] wr_pos;
  logic [PTR_W-1:0] top_ptr;
  logic             eff_pop;

  assign eff_pop = pop && busy;
  assign busy    = (depth != '0);
  assign top_ptr = PTR_W'(depth - DEP_W'(1));
  assign top_lvl = busy ? slot[top_ptr] : '0;
  // a simultaneous pop and push replaces the top entry
  assign wr_pos  = eff_pop ? depth - DEP_W'(1) : depth;

  always_ff @(posedge clk) begin
    if (!rst_n) depth <= '0;
    else        depth <= depth - DEP_W'(eff_pop) + DEP_W'(push);
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                              slot[k] <= '0;
      else if (push && (wr_pos == DEP_W'(k)))  slot[k] <= push_lvl;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !eff_pop) |-> (depth < DEP_W'(NUM_LVL)));       // R9
  AST_STRICT_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (push && busy && !eff_pop) |-> (push_lvl < top_lvl));    // R6
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !busy) |=> !busy);                      // R8
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 40,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       irq_req,
  input  logic [N_SRC-1:0]       irq_mask,
  input  logic [N_SRC*LVL_W-1:0] irq_level,
  input  logic                   core_id,
  input  logic                   core_np,
  output logic                   ack_valid,
  input  logic                   ack_ready,
  output logic [IDX_W-1:0]       ack_index,
  output logic [LVL_W-1:0]       ack_level,
  input  logic                   svc_done
);
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] clr;
  logic             win_v;
  lvl_t             win_lvl;
  logic [IDX_W-1:0] win_idx;
  logic             svc_busy;
  lvl_t             svc_top;
  logic             core_open;
  logic             outranks;
  logic             fire;

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(clr), .pend(pend)
  );

  assign elig = pend & ~irq_mask;

  irq_arb_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .lvl_flat(irq_level),
    .win_v(win_v), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  irq_svc_stack u_stack (
    .clk(clk), .rst_n(rst_n), .push(fire), .push_lvl(win_lvl),
    .pop(svc_done), .busy(svc_busy), .top_lvl(svc_top)
  );

  assign core_open = !core_id && !core_np;
  assign outranks  = !svc_busy || (win_lvl < svc_top);
  assign ack_valid = win_v && core_open && outranks;
  assign ack_index = win_idx;
  assign ack_level = win_lvl;
  assign fire      = ack_valid && ack_ready;

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr[i] = fire && (win_idx == IDX_W'(i));
  end

  AST_CORE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (core_id || core_np) |-> !ack_valid);                    // R5
  AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (pend[ack_index] && !irq_mask[ack_index]));  // R2
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clr) <= 1);                                   // R7
endmodule

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb_top;
  localparam int N  = 40;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_req;
  logic [N-1:0]  irq_mask;
  logic [3*N-1:0] irq_level;
  logic          core_id, core_np;
  logic          ack_valid, ack_ready, svc_done;
  logic [IW-1:0] ack_index;
  logic [2:0]    ack_level;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  irq_prio_arb #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
    .irq_level(irq_level), .core_id(core_id), .core_np(core_np),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_index(ack_index),
    .ack_level(ack_level), .svc_done(svc_done)
  );

  task automatic chk(string rq, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic look();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = '0; irq_mask = '0; irq_level = '0;
    core_id = 1'b0; core_np = 1'b0; ack_ready = 1'b0; svc_done = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_lvl(int s, int l);
    irq_level[s*3 +: 3] = 3'(l);
  endtask

  task automatic pulse(int s);
    irq_req[s] = 1'b1; tick(); irq_req[s] = 1'b0;
  endtask

  task automatic accept();
    ack_ready = 1'b1; tick(); ack_ready = 1'b0;
  endtask

  task automatic done();
    svc_done = 1'b1; tick(); svc_done = 1'b0;
  endtask

  task automatic expect_offer(string rq, int idx, int lvl);
    look();
    chk(rq, "valid", int'(ack_valid), 1);
    chk(rq, "index", int'(ack_index), idx);
    chk(rq, "level", int'(ack_level), lvl);
  endtask

  task automatic expect_none(string rq);
    look();
    chk(rq, "valid", int'(ack_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    expect_none("R1");
  endtask

  task automatic t_single();
    do_reset();
    set_lvl(7, 5);
    pulse(7);
    expect_offer("R1", 7, 5);
    for (int i = 0; i < 3; i++) tick();
    expect_offer("R7", 7, 5);          // held under back-pressure
    accept();
    expect_none("R7");
    done();
    expect_none("R7");                 // pending was cleared
  endtask

  task automatic t_prio();
    do_reset();
    set_lvl(3, 6); set_lvl(20, 2);
    irq_req[3] = 1'b1; irq_req[20] = 1'b1; tick(); irq_req = '0;
    expect_offer("R3", 20, 2);
    accept(); done();
    expect_offer("R3", 3, 6);
  endtask

  task automatic t_tie();
    do_reset();
    set_lvl(30, 4); set_lvl(10, 4); set_lvl(39, 4);
    irq_req[30] = 1'b1; irq_req[10] = 1'b1; irq_req[39] = 1'b1;
    tick(); irq_req = '0;
    expect_offer("R4", 10, 4);
    accept(); done();
    expect_offer("R4", 30, 4);
  endtask

  task automatic t_mask();
    do_reset();
    set_lvl(5, 1);
    irq_mask[5] = 1'b1;
    pulse(5);
    expect_none("R2");
    for (int i = 0; i < 4; i++) tick();
    expect_none("R2");
    irq_mask[5] = 1'b0;
    expect_offer("R2", 5, 1);
  endtask

  task automatic t_block();
    do_reset();
    set_lvl(12, 3);
    core_id = 1'b1;
    pulse(12);
    expect_none("R5");
    core_id = 1'b0; core_np = 1'b1;
    tick();
    expect_none("R5");
    core_np = 1'b0;
    expect_offer("R5", 12, 3);
  endtask

  task automatic t_nest();
    do_reset();
    set_lvl(1, 3); set_lvl(2, 3); set_lvl(4, 1);
    pulse(1);
    accept();                          // in service at level 3
    pulse(2);
    expect_none("R6");                 // equal level waits
    pulse(4);
    expect_offer("R6", 4, 1);
    accept();                          // stack 3,1
    expect_none("R6");
    done();                            // top back to 3
    expect_none("R8");
    done();                            // empty
    expect_offer("R8", 2, 3);
  endtask

  task automatic t_pop_empty();
    do_reset();
    done();                            // ignored on empty stack
    set_lvl(8, 4); set_lvl(9, 4);
    pulse(8);
    accept();
    pulse(9);
    expect_none("R8");
    done();
    expect_offer("R8", 9, 4);
  endtask

  task automatic t_deep();
    do_reset();
    for (int k = 0; k < 8; k++) begin
      set_lvl(10 + k, 7 - k);
      pulse(10 + k);
      expect_offer("R9", 10 + k, 7 - k);
      accept();
    end
    set_lvl(30, 0);
    pulse(30);
    expect_none("R9");                 // level 0 already in service
    done();
    expect_offer("R9", 30, 0);
  endtask

  task automatic t_clear_wins();
    do_reset();
    set_lvl(6, 2);
    pulse(6);
    expect_offer("R10", 6, 2);
    ack_ready = 1'b1; irq_req[6] = 1'b1;
    tick();
    ack_ready = 1'b0; irq_req[6] = 1'b0;
    done();
    expect_none("R10");
  endtask

  initial begin
    t_reset();
    t_single();
    t_prio();
    t_tie();
    t_mask();
    t_block();
    t_nest();
    t_pop_empty();
    t_deep();
    t_clear_wins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule